// File: doc/BRIEF.md
# Unlock Sequence and Register Bank Selector

This block sits on the host side of an eight-port digital I/O device and decides how register accesses are decoded. Out of reset the device is in standard mode. The block watches host writes to the control port, which is port address 7, for a fixed four-byte key. When the full key arrives it switches the device into enhanced mode.

In enhanced mode the same control port address becomes a bank selector. Writes to it choose which of three register banks (0, 1 or 2) the remaining port addresses 0 to 6 decode into. The current mode and bank are driven as plain registered outputs to the downstream register decode logic. That logic owns the contents of the banked registers. Enhanced mode is left only through reset.

Top module: `unlock_bank_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `enh_mode` is 0 and `bank` is 0.
- R2: Four writes to address 7 carrying 0x07, 0x0D, 0x06 and 0x12, in that order, set `enh_mode` to 1 in the cycle after the fourth write. Cycles with no write strobe may fall between the key writes.
- R3: In standard mode, a write to address 7 whose byte is not the next expected key byte discards the partial key. If that byte is 0x07, it counts as the first byte of a new attempt.
- R4: In standard mode, a write to any address other than 7 discards the partial key.
- R5: Read strobes, whatever the address, have no effect on key matching, mode or bank.
- R6: When enhanced mode is entered, `bank` is 0. While in standard mode, `bank` stays 0.
- R7: In enhanced mode, a write to address 7 selects a bank in the next cycle: 0x00 selects bank 0, 0x40 selects bank 1 and 0x80 selects bank 2.
- R8: In enhanced mode, a write to address 7 with any other byte leaves `bank` unchanged. `bank` never reads 3.
- R9: Once set, `enh_mode` stays 1 until reset, whatever is written.
- R10: In enhanced mode, writes to addresses 0 to 6 leave `bank` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Port address of the host access |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| enh_mode | output | 1 | 1 while in enhanced mode |
| bank | output | 2 | Active register bank |

## Verification
The inline assertions check the following on every cycle:
- Enhanced mode can only rise in the cycle after a write of the last key byte to the control port.
- Enhanced mode never falls outside reset.
- The bank is 0 on entry and throughout standard mode.
- The bank never takes the value 3.
- The bank holds through reads, through writes to other ports and through unlisted bytes.

Whether the matcher tracks key progress correctly can only be shown by the directed scenarios. These cover a wrong byte midway, a restart on 0x07, an abort on another address, and idle gaps between key writes.

// File: rtl/unlock_bank_sel.sv
module unlock_bank_sel #(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int CTRL_PORT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          enh_mode,
  output logic [1:0]    bank
);

  localparam logic [DW-1:0] KEY0 = DW'(8'h07);
  localparam logic [DW-1:0] KEY1 = DW'(8'h0D);
  localparam logic [DW-1:0] KEY2 = DW'(8'h06);
  localparam logic [DW-1:0] KEY3 = DW'(8'h12);
  localparam logic [DW-1:0] SEL0 = DW'(8'h00);
  localparam logic [DW-1:0] SEL1 = DW'(8'h40);
  localparam logic [DW-1:0] SEL2 = DW'(8'h80);

  logic [1:0]    step;
  logic [DW-1:0] want;
  logic          ctrl_wr, other_wr, hit;

  assign ctrl_wr  = wr_en && (addr == AW'(CTRL_PORT));
  assign other_wr = wr_en && (addr != AW'(CTRL_PORT));

  always_comb begin
    case (step)
      2'd0:    want = KEY0;
      2'd1:    want = KEY1;
      2'd2:    want = KEY2;
      default: want = KEY3;
    endcase
  end

  assign hit = (wdata == want);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= 2'd0;
      enh_mode <= 1'b0;
      bank     <= 2'd0;
    end else if (!enh_mode) begin
      if (other_wr)
        step <= 2'd0;
      else if (ctrl_wr) begin
        if (hit && step == 2'd3) begin
          enh_mode <= 1'b1;
          bank     <= 2'd0;
          step     <= 2'd0;
        end else if (hit)
          step <= step + 2'd1;
        else
          step <= (wdata == KEY0) ? 2'd1 : 2'd0;
      end
    end else if (ctrl_wr) begin
      case (wdata)
        SEL0:    bank <= 2'd0;
        SEL1:    bank <= 2'd1;
        SEL2:    bank <= 2'd2;
        default: bank <= bank;
      endcase
    end
  end

  AST_ENTRY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> $past(ctrl_wr && wdata == KEY3)); // R2
  AST_ENTRY_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> bank == 2'd0); // R6
  AST_STD_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> bank == 2'd0); // R6
  AST_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode |=> enh_mode); // R9
  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bank != 2'd3); // R8
  AST_BANK_ODD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && ctrl_wr && wdata != SEL0 && wdata != SEL1 && wdata != SEL2)
      |=> $stable(bank)); // R8
  AST_OTHER_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && !ctrl_wr) |=> $stable(bank)); // R10
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> ($stable(enh_mode) && $stable(bank))); // R5

endmodule

// File: tb/tb_unlock_bank_sel.sv
module tb_unlock_bank_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       enh_mode;
  logic [1:0] bank;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  unlock_bank_sel dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .enh_mode(enh_mode), .bank(bank)
  );

  task automatic check(input string req, input logic exp_m, input logic [1:0] exp_b);
    n_chk++;
    if (enh_mode !== exp_m || bank !== exp_b) begin
      n_bad++;
      $display("FAIL %s: mode=%0b bank=%0d, expected mode=%0b bank=%0d",
               req, enh_mode, bank, exp_m, exp_b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h06); wr(3'd7, 8'h12);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", 1'b0, 2'd0);
    @(negedge clk);
    check("R1", 1'b0, 2'd0);
  endtask

  task automatic t_unlock();
    do_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h06);
    check("R2", 1'b0, 2'd0);
    wr(3'd7, 8'h12);
    check("R2", 1'b1, 2'd0);
    check("R6", 1'b1, 2'd0);
    do_reset();
    wr(3'd7, 8'h07); @(negedge clk); wr(3'd7, 8'h0D); @(negedge clk);
    @(negedge clk); wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R2", 1'b1, 2'd0);
  endtask

  task automatic t_wrong_byte();
    do_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h55);
    wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R3", 1'b0, 2'd0);
    do_reset();
    wr(3'd7, 8'h0D); wr(3'd7, 8'h06); wr(3'd7, 8'h12); wr(3'd7, 8'h12);
    check("R3", 1'b0, 2'd0);
    do_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h07);
    wr(3'd7, 8'h0D); wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R3", 1'b1, 2'd0);
    do_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h07); wr(3'd7, 8'h0D);
    wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R3", 1'b1, 2'd0);
  endtask

  task automatic t_abort();
    do_reset();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd3, 8'h06);
    wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R4", 1'b0, 2'd0);
    unlock();
    check("R4", 1'b1, 2'd0);
  endtask

  task automatic t_reads();
    do_reset();
    wr(3'd7, 8'h07); rd(3'd7); wr(3'd7, 8'h0D); rd(3'd2);
    wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R5", 1'b1, 2'd0);
    wr(3'd7, 8'h40);
    rd(3'd7); rd(3'd0);
    check("R5", 1'b1, 2'd1);
  endtask

  task automatic t_banks();
    do_reset();
    wr(3'd7, 8'h40);
    check("R6", 1'b0, 2'd0);
    unlock();
    wr(3'd7, 8'h40); check("R7", 1'b1, 2'd1);
    wr(3'd7, 8'h80); check("R7", 1'b1, 2'd2);
    wr(3'd7, 8'h00); check("R7", 1'b1, 2'd0);
    wr(3'd7, 8'h80); check("R7", 1'b1, 2'd2);
  endtask

  task automatic t_ignored();
    do_reset();
    unlock();
    wr(3'd7, 8'h80);
    wr(3'd7, 8'hC0); check("R8", 1'b1, 2'd2);
    wr(3'd7, 8'h41); check("R8", 1'b1, 2'd2);
    wr(3'd7, 8'h40);
    wr(3'd7, 8'hFF); check("R8", 1'b1, 2'd1);
    for (int a = 0; a < 7; a++) wr(3'(a), 8'h80);
    check("R10", 1'b1, 2'd1);
    wr(3'd0, 8'h00); check("R10", 1'b1, 2'd1);
  endtask

  task automatic t_persist();
    do_reset();
    unlock();
    wr(3'd7, 8'h07); wr(3'd7, 8'h0D); wr(3'd7, 8'h06); wr(3'd7, 8'h12);
    check("R9", 1'b1, 2'd0);
    for (int i = 0; i < 8; i++) wr(3'(i), 8'(i * 37));
    check("R9", 1'b1, 2'd0);
    do_reset();
    check("R1", 1'b0, 2'd0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_unlock();
    t_wrong_byte();
    t_abort();
    t_reads();
    t_banks();
    t_ignored();
    t_persist();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule